// File: doc/BRIEF.md
# Timer Clock Prescale and Divide Tree

This block produces one tick enable for each of five timer channels, all in the bus clock domain. Two shared 8-bit prescalers slow the bus clock down. Channels 0 and 1 hang off prescaler A, and channels 2, 3 and 4 hang off prescaler B. Each channel then divides its prescaled tick by a power of two that it picks itself. Instead of the divided tick, a channel can forward rising edges of an external clock after a two-flop synchronizer. Channels 0 and 1 watch external input 0. Channels 2 to 4 watch external input 1.

Configuration arrives as simple write strobes. One write loads both prescaler values at once. A field write replaces the 4-bit select code of a single channel. A rate-ratio request lets software ask for a divisor: the request is rounded up to the nearest allowed power of two and stored in that channel's field. A request outside the legal range is dropped. Every tick output is a one-bus-clock pulse that the timer counters use as a count enable.

Each channel runs a small state machine with three states:
- CH_RESTART: the divider phase is cleared.
- CH_DIVIDE: the channel counts prescaled ticks.
- CH_EXTERN: the channel forwards external edges.

Its transitions are:
- restart: any configuration write touching the channel sends it from any state to CH_RESTART.
- pick-divide: from CH_RESTART to CH_DIVIDE when the code is not the external code.
- pick-external: from CH_RESTART to CH_EXTERN when the code is 4.
- hold: CH_DIVIDE and CH_EXTERN otherwise stay where they are.

Top module: `tclk_tree`

## Requirements
- R1: A prescaler holding value P emits a prescaled tick once every P+1 bus clocks. A channel in divide mode with divisor D therefore pulses every D*(P+1) bus clocks.
- R2: In the prescaler write data, bits [7:0] set prescaler A, which drives channels 0 and 1. Bits [15:8] set prescaler B, which drives channels 2, 3 and 4.
- R3: Select code n in 0..3 divides the prescaled tick by 2^(n+1), giving 2, 4, 8 or 16.
- R4: Select code 4 makes the channel emit one tick per rising edge of its external clock. Channels 0 and 1 follow ext_clk[0], and channels 2 to 4 follow ext_clk[1]. Edges on the other external input produce no tick.
- R5: Select codes 5 to 15 behave as divide by 16.
- R6: A field write changes only the addressed channel's code. Other channels keep their codes, and an index of 5 or above changes nothing.
- R7: A rate-ratio request with ratio r in 1..16 stores a code by rounding up: r of 1 or 2 gives code 0, r of 3 or 4 gives code 1, r of 5 to 8 gives code 2, and r of 9 to 16 gives code 3.
- R8: A rate-ratio request with r = 0 or r > 16 is ignored.
- R9: A rate-ratio request to a channel whose code is 4 is ignored, and the channel stays in external mode.
- R10: While reset is asserted every tick is low. Reset leaves both prescalers at 0 and all codes at 0, so each channel pulses every 2 clocks. No tick is ever high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_wr | input | 1 | Load both prescaler values |
| pre_wdata | input | 16 | Prescaler A in [7:0], prescaler B in [15:8] |
| sel_wr | input | 1 | Write one channel's select code |
| sel_idx | input | 3 | Channel addressed by sel_wr |
| sel_code | input | 4 | New select code |
| rate_wr | input | 1 | Rate-ratio request strobe |
| rate_idx | input | 3 | Channel addressed by rate_wr |
| rate_ratio | input | 8 | Requested ratio of prescaled rate to tick rate |
| ext_clk | input | 2 | Asynchronous external clocks 0 and 1 |
| tick | output | 5 | Per-channel one-cycle tick enables |

## Verification
Several properties are checked on every cycle by the assertions:
- the prescaler count stays within its limit;
- a channel in CH_DIVIDE ticks only right after a prescaled tick;
- a channel in CH_EXTERN ticks only right after a synchronized edge;
- no tick lasts two cycles;
- fields not addressed by a write stay stable, and an external-mode code survives any rate request.

The exact tick spacing for each prescaler and code, the sharing of prescalers and external inputs between channels, and the rounding and rejection of rate requests depend on whole sequences of configuration. Only the bench's directed and random scenarios, which measure spacing between ticks at the outputs, can show these.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    // Per-channel mode state machine.
    typedef enum logic [1:0] {
        CH_RESTART = 2'd0,
        CH_DIVIDE  = 2'd1,
        CH_EXTERN  = 2'd2
    } ch_state_e;

    // Select code that routes the external clock.
    localparam logic [3:0] CODE_EXT = 4'd4;

    // Width of the per-channel divide counter (largest divisor 16).
    localparam int DIV_CNT_W = 4;

endpackage

// File: rtl/tclk_prescaler.sv
module tclk_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] pvalue,
    output logic             pre_tick
);

    logic [PRE_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == pvalue);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pre_tick <= 1'b0;
        end else if (restart) begin
            cnt_q    <= '0;
            pre_tick <= 1'b0;
        end else begin
            cnt_q    <= wrap ? '0 : cnt_q + 1'b1;
            pre_tick <= wrap;
        end
    end

    // R1: the count never passes the programmed limit
    assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= pvalue);

    // R1: with a nonzero value, prescaled ticks are never back to back
    assert_pre_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && pvalue != '0 && !restart) |=> !pre_tick);

endmodule

// File: rtl/tclk_edge_sync.sv
module tclk_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic edge_pulse
);

    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign edge_pulse = sync_q & ~last_q;

    // R4: one rising edge yields a single-cycle pulse
    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/tclk_channel.sv
module tclk_channel
    import tclk_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] code,
    input  logic             pre_tick,
    input  logic             ext_edge,
    output logic             tick
);

    ch_state_e            state_q, state_d;
    logic [DIV_CNT_W-1:0] dcnt_q, dcnt_d;
    logic                 tick_d;
    logic [1:0]           div_exp;
    logic [DIV_CNT_W-1:0] term;
    logic                 is_ext;

    // Codes 0..3 pick 2^(n+1); every other non-external code acts as /16.
    always_comb begin
        if (code < SEL_W'(4)) div_exp = code[1:0];
        else                  div_exp = 2'd3;
    end

    assign term   = DIV_CNT_W'((5'd2 << div_exp) - 5'd1);
    assign is_ext = (code == SEL_W'(CODE_EXT));

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = CH_RESTART;
        end else begin
            unique case (state_q)
                CH_RESTART: state_d = is_ext ? CH_EXTERN : CH_DIVIDE;
                CH_DIVIDE:  state_d = CH_DIVIDE;
                CH_EXTERN:  state_d = CH_EXTERN;
                default:    state_d = CH_RESTART;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_RESTART;
        else        state_q <= state_d;
    end

    // Output and divider counter.
    always_comb begin
        dcnt_d = dcnt_q;
        tick_d = 1'b0;
        if (restart) begin
            dcnt_d = '0;
        end else begin
            unique case (state_q)
                CH_RESTART: dcnt_d = '0;
                CH_DIVIDE: begin
                    if (pre_tick) begin
                        if (dcnt_q >= term) begin
                            dcnt_d = '0;
                            tick_d = 1'b1;
                        end else begin
                            dcnt_d = dcnt_q + 1'b1;
                        end
                    end
                end
                CH_EXTERN: tick_d = ext_edge;
                default:   dcnt_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            tick   <= 1'b0;
        end else begin
            dcnt_q <= dcnt_d;
            tick   <= tick_d;
        end
    end

    // R3: divider count stays below the selected divisor
    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt_q <= term);

    // R3: a dividing channel only ticks after a prescaled tick
    assert_div_needs_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DIVIDE && !pre_tick) |=> !tick);

    // R4: an external-mode channel only ticks after a synchronized edge
    assert_ext_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EXTERN && !ext_edge) |=> !tick);

    // R10: ticks are single-cycle pulses
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tclk_tree.sv
module tclk_tree
    import tclk_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 4,
    parameter int SPLIT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_wr,
    input  logic [2*PRE_W-1:0]         pre_wdata,
    input  logic                       sel_wr,
    input  logic [$clog2(NUM_CH)-1:0]  sel_idx,
    input  logic [SEL_W-1:0]           sel_code,
    input  logic                       rate_wr,
    input  logic [$clog2(NUM_CH)-1:0]  rate_idx,
    input  logic [PRE_W-1:0]           rate_ratio,
    input  logic [1:0]                 ext_clk,
    output logic [NUM_CH-1:0]          tick
);

    localparam int IDX_W = $clog2(NUM_CH);
    localparam logic [PRE_W-1:0] RATIO_MAX = PRE_W'(16);

    logic [2*PRE_W-1:0] pre_q;
    logic [SEL_W-1:0]   sel_q [NUM_CH];
    logic [NUM_CH-1:0]  wr_hit, rate_hit, ch_restart;
    logic               rate_ok;
    logic [SEL_W-1:0]   rate_code;
    logic [1:0]         pre_tick, ext_edge;

    // Round the requested ratio up to the next allowed divisor.
    function automatic logic [SEL_W-1:0] ratio_to_code(input logic [PRE_W-1:0] r);
        if (r <= PRE_W'(2))      return SEL_W'(0);
        else if (r <= PRE_W'(4)) return SEL_W'(1);
        else if (r <= PRE_W'(8)) return SEL_W'(2);
        else                     return SEL_W'(3);
    endfunction

    assign rate_ok   = rate_wr && (rate_ratio != '0) && (rate_ratio <= RATIO_MAX);
    assign rate_code = ratio_to_code(rate_ratio);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            wr_hit[i]     = sel_wr && (sel_idx == IDX_W'(i));
            rate_hit[i]   = rate_ok && (rate_idx == IDX_W'(i)) && !wr_hit[i]
                            && (sel_q[i] != SEL_W'(CODE_EXT));
            ch_restart[i] = pre_wr | wr_hit[i] | rate_hit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            for (int i = 0; i < NUM_CH; i++) sel_q[i] <= '0;
        end else begin
            if (pre_wr) pre_q <= pre_wdata;
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_hit[i])        sel_q[i] <= sel_code;
                else if (rate_hit[i]) sel_q[i] <= rate_code;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        tclk_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (pre_wr),
            .pvalue   (pre_q[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick[g])
        );
        tclk_edge_sync u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .ext_in     (ext_clk[g]),
            .edge_pulse (ext_edge[g])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = (i < SPLIT) ? 0 : 1;

        tclk_channel #(.SEL_W(SEL_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (ch_restart[i]),
            .code     (sel_q[i]),
            .pre_tick (pre_tick[GRP]),
            .ext_edge (ext_edge[GRP]),
            .tick     (tick[i])
        );

        // R6: a field no write addressed keeps its code
        assert_field_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_hit[i] || rate_hit[i]) |=> $stable(sel_q[i]));

        // R9: only a field write can take a channel out of external mode
        assert_ext_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[i] == SEL_W'(CODE_EXT) && !wr_hit[i]) |=> (sel_q[i] == SEL_W'(CODE_EXT)));
    end

endmodule

// File: tb/tb_tclk_tree.sv
module tb_tclk_tree;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_wr = 1'b0;
    logic [15:0] pre_wdata = '0;
    logic        sel_wr = 1'b0;
    logic [2:0]  sel_idx = '0;
    logic [3:0]  sel_code = '0;
    logic        rate_wr = 1'b0;
    logic [2:0]  rate_idx = '0;
    logic [7:0]  rate_ratio = '0;
    logic [1:0]  ext_clk = '0;
    logic [NCH-1:0] tick;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    int ext_half [2] = '{0, 0};
    int ext_cnt [2] = '{0, 0};

    tclk_tree dut (
        .clk(clk), .rst_n(rst_n), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .sel_wr(sel_wr), .sel_idx(sel_idx), .sel_code(sel_code),
        .rate_wr(rate_wr), .rate_idx(rate_idx), .rate_ratio(rate_ratio),
        .ext_clk(ext_clk), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // External clock generators, changed away from the active edge.
    always @(negedge clk) begin
        for (int e = 0; e < 2; e++) begin
            if (ext_half[e] > 0) begin
                if (ext_cnt[e] + 1 >= ext_half[e]) begin
                    ext_cnt[e] <= 0;
                    ext_clk[e] <= ~ext_clk[e];
                end else begin
                    ext_cnt[e] <= ext_cnt[e] + 1;
                end
            end
        end
    end

    function automatic int exp_div(input int code);
        if (code < 4) return 2 << code;
        return 16;
    endfunction

    function automatic int exp_ratio_div(input int r);
        if (r <= 2) return 2;
        if (r <= 4) return 4;
        if (r <= 8) return 8;
        return 16;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic write_pre(input int a, input int b);
        @(negedge clk);
        pre_wr = 1'b1; pre_wdata = {8'(b), 8'(a)};
        @(negedge clk);
        pre_wr = 1'b0;
    endtask

    task automatic write_sel(input int ch, input int code);
        @(negedge clk);
        sel_wr = 1'b1; sel_idx = 3'(ch); sel_code = 4'(code);
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic write_rate(input int ch, input int r);
        @(negedge clk);
        rate_wr = 1'b1; rate_idx = 3'(ch); rate_ratio = 8'(r);
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic wait_tick(input int ch, output int at);
        at = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (tick[ch]) begin
                at = cyc;
                return;
            end
        end
    endtask

    // Spacing between two ticks, after discarding the first one.
    task automatic measure(input int ch, output int iv);
        int a, b, c;
        wait_tick(ch, a);
        wait_tick(ch, b);
        wait_tick(ch, c);
        if (a < 0 || b < 0 || c < 0) iv = -1;
        else iv = c - b;
    endtask

    task automatic count_ticks(input int ch, input int win, output int n);
        n = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (tick[ch]) n++;
        end
    endtask

    initial begin
        int iv, n, p0, p1, ch, code, hi;
        void'($urandom(32'h5eed_1234));

        // R10: no ticks during reset
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (tick != '0) hi++;
        end
        check("R10 reset ticks low", hi, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset defaults give divide by 2 on every channel
        for (int c = 0; c < NCH; c++) begin
            measure(c, iv);
            check("R10 reset default interval", iv, 2);
        end

        // R1, R2: prescaler sharing
        write_pre(2, 5);
        measure(0, iv); check("R2 ch0 uses prescaler A", iv, 2 * 3);
        measure(1, iv); check("R2 ch1 uses prescaler A", iv, 2 * 3);
        measure(3, iv); check("R2 ch3 uses prescaler B", iv, 2 * 6);
        write_sel(4, 2);
        measure(4, iv); check("R1 ch4 code2 prescaler B", iv, 8 * 6);

        // R3: each code
        write_pre(1, 0);
        for (int c2 = 0; c2 < 4; c2++) begin
            write_sel(0, c2);
            measure(0, iv);
            check("R3 code divide", iv, exp_div(c2) * 2);
        end

        // R5: unused codes act as /16
        write_sel(2, 9);
        measure(2, iv); check("R5 code 9 divides by 16", iv, 16);
        write_sel(3, 15);
        measure(3, iv); check("R5 code 15 divides by 16", iv, 16);

        // R6: field isolation
        write_sel(0, 1);
        write_sel(1, 2);
        write_sel(1, 0);
        measure(0, iv); check("R6 ch0 unchanged by ch1 write", iv, 4 * 2);
        write_sel(6, 0);
        measure(2, iv); check("R6 index 6 changes nothing", iv, 16);

        // R7: rate request rounding (prescaler A = 3)
        write_pre(3, 0);
        write_rate(1, 3);
        measure(1, iv); check("R7 ratio 3 -> /4", iv, exp_ratio_div(3) * 4);
        write_rate(1, 1);
        measure(1, iv); check("R7 ratio 1 -> /2", iv, exp_ratio_div(1) * 4);
        write_rate(1, 9);
        measure(1, iv); check("R7 ratio 9 -> /16", iv, exp_ratio_div(9) * 4);
        write_rate(1, 5);
        measure(1, iv); check("R7 ratio 5 -> /8", iv, exp_ratio_div(5) * 4);
        write_rate(1, 16);
        measure(1, iv); check("R7 ratio 16 -> /16", iv, 64);

        // R8: out-of-range requests ignored
        write_rate(1, 4);
        write_rate(1, 17);
        measure(1, iv); check("R8 ratio 17 ignored", iv, 4 * 4);
        write_rate(1, 0);
        measure(1, iv); check("R8 ratio 0 ignored", iv, 4 * 4);

        // R4: external clocks and their grouping
        ext_half[1] = 7;
        write_sel(2, 4);
        write_sel(3, 4);
        measure(2, iv); check("R4 ch2 follows ext1", iv, 14);
        measure(3, iv); check("R4 ch3 follows ext1", iv, 14);
        write_sel(0, 4);
        count_ticks(0, 120, n); check("R4 ch0 ignores ext1", n, 0);
        ext_half[0] = 5;
        measure(0, iv); check("R4 ch0 follows ext0", iv, 10);

        // R9: rate request on an external-mode channel ignored
        write_rate(2, 8);
        measure(2, iv); check("R9 ext channel keeps ext mode", iv, 14);
        ext_half[0] = 0;
        ext_half[1] = 0;

        // R1, R3, R5: random configurations
        for (int it = 0; it < 12; it++) begin
            p0 = int'($urandom_range(0, 7));
            p1 = int'($urandom_range(0, 7));
            ch = int'($urandom_range(0, NCH - 1));
            code = int'($urandom_range(0, 15));
            if (code == 4) code = 3;
            write_pre(p0, p1);
            write_sel(ch, code);
            measure(ch, iv);
            check("R1 random config", iv, exp_div(code) * (((ch < 2) ? p0 : p1) + 1));
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule